// File: doc/BRIEF.md
# Partial-Word Store Byte-Lane Unit

This block turns a "store bytes" request into exactly one write beat on a word-wide memory port with per-byte enables. A request carries a byte address, a data word and a fill-mode bit. In begin mode the block writes the bytes from the addressed byte to the end of its word. In end mode it writes the bytes of the word that come before the addressed byte. Memory is big-endian: the lowest-addressed byte of a word sits in data bits 31:24.

Every case, including the two three-byte cases, leaves as one aligned-word beat, so no other observer can see a partly written word. When end mode is used with an aligned address, no byte is written. The block still issues a beat with every enable cleared and a probe flag raised, so that the memory side can check write permission and mark the line dirty. The request side and the memory side each use a valid/ready handshake. One registered stage sits between them and holds a beat until the memory side accepts it.

Top module: `sbl_store_unit`

## Requirements
- R1: In begin mode (`req_end`=0) with byte offset o = `req_addr[1:0]`, the enables are 1111 shifted right by o (o=0:1111, 1:0111, 2:0011, 3:0001). Enable bit 3 is the lowest-addressed byte, data bits 31:24.
- R2: In end mode (`req_end`=1) the enables are o=1:1000, o=2:1100, o=3:1110, o=0:0000.
- R3: Each enabled lane of `mem_wdata` carries the request's data bits in the same lane position. Every disabled lane is driven to zero.
- R4: End mode with offset 0 produces a beat with `mem_probe`=1 and all enables clear. Every other request produces `mem_probe`=0.
- R5: `mem_addr` is the word address `req_addr[ADDR_W-1:2]`.
- R6: Each accepted request produces exactly one memory beat, the three-byte cases included.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` both high) shows on the memory port (`mem_valid`=1) right after that edge.
- R8: While `mem_valid` is high and `mem_ready` is low, the beat's address, enables, data and probe flag stay unchanged, and `req_ready` is low.
- R9: `req_ready` is high whenever no beat is pending or the pending beat is being accepted in the same cycle, so requests can be accepted on every cycle.
- R10: After reset `mem_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | DATA_W | Store data |
| req_end | input | 1 | Fill mode: 0 begin, 1 end |
| mem_valid | output | 1 | Beat present on the memory port |
| mem_ready | input | 1 | Memory side takes the beat |
| mem_addr | output | ADDR_W-2 | Aligned word address |
| mem_wdata | output | DATA_W | Lane-placed write data |
| mem_be | output | DATA_W/8 | Byte enables; the top bit is the lowest address |
| mem_probe | output | 1 | Zero-byte permission probe |

## Verification
Two functions can fall in the same clock edge: the memory side retiring the held beat, and the request side loading a new beat into the same register. The bench provokes this in two ways. First, it holds `req_valid` high over several cycles with `mem_ready` high, which gives back-to-back transfers. Second, it stalls a beat and then raises `mem_ready` while a second request is already waiting. In each case the bench requires every beat to appear exactly once, in order, with its own lanes. It also requires that the waiting request was never taken while the port was stalled.

// File: rtl/sbl_pkg.sv
// Package: shared types for the store byte-lane unit.
// Assumes: nothing beyond standard SystemVerilog.
package sbl_pkg;

    // Fill mode selecting which side of the addressed byte is written
    typedef enum logic {
        FILL_HEAD_FROM_ADDR = 1'b0,   // begin: addressed byte to end of word
        FILL_UP_TO_ADDR     = 1'b1    // end: start of word up to addressed byte
    } fill_mode_e;

endpackage

// File: rtl/sbl_lane_decode.sv
// Module: sbl_lane_decode
// Purpose: from the byte offset and fill mode, derive the per-lane write
//          enables and the zero-length probe flag.
// Assumes: lane 0 is the lowest address and maps to the top enable bit
//          (big-endian memory).
module sbl_lane_decode
    import sbl_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic [OFS_W-1:0] ofs,
    input  fill_mode_e       mode,
    output logic [LANES-1:0] be,
    output logic             probe
);

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            // Enable of address lane gi: after the offset in begin mode, before it in end mode
            always_comb begin
                if (mode == FILL_UP_TO_ADDR)
                    be[LANES-1-gi] = (OFS_W'(gi) < ofs);
                else
                    be[LANES-1-gi] = (OFS_W'(gi) >= ofs);
            end
        end
    endgenerate

    // Probe raised only for the empty end-mode case
    always_comb probe = (mode == FILL_UP_TO_ADDR) && (ofs == '0);

endmodule

// File: rtl/sbl_data_steer.sv
// Module: sbl_data_steer
// Purpose: place store data on the byte lanes and zero every disabled lane.
// Assumes: the data needs no shift in either mode (begin mode keeps the low
//          bytes in the trailing lanes, end mode keeps the high bytes in the
//          leading lanes), so only masking is required.
module sbl_data_steer #(
    parameter int LANES = 4,
    localparam int DATA_W = LANES * 8
) (
    input  logic [DATA_W-1:0] din,
    input  logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] dout
);

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_steer
            // Pass the lane byte when enabled, otherwise drive zero
            always_comb dout[gl*8 +: 8] = be[gl] ? din[gl*8 +: 8] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/sbl_beat_reg.sv
// Module: sbl_beat_reg
// Purpose: single registered stage between the request handshake and the
//          memory handshake; holds a beat until the memory side takes it.
// Assumes: synchronous active-low reset; the upstream may present a request
//          every cycle.
module sbl_beat_reg #(
    parameter int WADDR_W = 30,
    parameter int LANES   = 4,
    localparam int DATA_W = LANES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [LANES-1:0]   in_be,
    input  logic               in_probe,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0]  out_data,
    output logic [LANES-1:0]   out_be,
    output logic               out_probe
);

    logic take;

    // Space exists when empty or when the held beat leaves this cycle
    always_comb in_ready = !out_valid || out_ready;

    // A new beat enters on a request handshake
    always_comb take = in_valid && in_ready;

    // Valid flag: set on load, cleared when the beat leaves without replacement
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (take)
            out_valid <= 1'b1;
        else if (out_ready)
            out_valid <= 1'b0;
    end

    // Beat payload: loaded only on a handshake, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr  <= '0;
            out_data  <= '0;
            out_be    <= '0;
            out_probe <= 1'b0;
        end else if (take) begin
            out_addr  <= in_addr;
            out_data  <= in_data;
            out_be    <= in_be;
            out_probe <= in_probe;
        end
    end

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data)
        && $stable(out_be) && $stable(out_probe)); // R8
    AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R7
    AST_RETIRE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid); // R6

endmodule

// File: rtl/sbl_store_unit.sv
// Module: sbl_store_unit
// Purpose: top level; decodes a partial-word store into one aligned beat
//          with byte enables, or a zero-byte probe beat.
// Assumes: big-endian lanes, DATA_W a power-of-two multiple of 8, and an
//          address wide enough to hold the byte offset.
module sbl_store_unit
    import sbl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES   = DATA_W / 8,
    localparam int OFS_W   = $clog2(LANES),
    localparam int WADDR_W = ADDR_W - OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_data,
    input  logic               req_end,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [LANES-1:0]   mem_be,
    output logic               mem_probe
);

    fill_mode_e          mode;
    logic [OFS_W-1:0]    ofs;
    logic [WADDR_W-1:0]  waddr;
    logic [LANES-1:0]    be_c;
    logic                probe_c;
    logic [DATA_W-1:0]   wdata_c;

    // Split the byte address into word address and byte offset
    always_comb begin
        mode  = fill_mode_e'(req_end);
        ofs   = req_addr[OFS_W-1:0];
        waddr = req_addr[ADDR_W-1:OFS_W];
    end

    sbl_lane_decode #(.LANES(LANES)) u_decode (
        .ofs   (ofs),
        .mode  (mode),
        .be    (be_c),
        .probe (probe_c)
    );

    sbl_data_steer #(.LANES(LANES)) u_steer (
        .din  (req_data),
        .be   (be_c),
        .dout (wdata_c)
    );

    sbl_beat_reg #(.WADDR_W(WADDR_W), .LANES(LANES)) u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_addr   (waddr),
        .in_data   (wdata_c),
        .in_be     (be_c),
        .in_probe  (probe_c),
        .out_valid (mem_valid),
        .out_ready (mem_ready),
        .out_addr  (mem_addr),
        .out_data  (mem_wdata),
        .out_be    (mem_be),
        .out_probe (mem_probe)
    );

    AST_PROBE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_probe |-> mem_be == '0 && mem_wdata == '0); // R4
    AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_probe |-> mem_be != '0); // R1
    AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |-> !req_ready); // R8
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> req_ready); // R9

endmodule

// File: tb/sbl_store_unit_tb.sv
module sbl_store_unit_tb_top;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        req_end = 1'b0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_probe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sbl_store_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_end(req_end),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_probe(mem_probe)
    );

    function automatic logic [3:0] exp_be(input logic endm, input logic [1:0] o);
        if (!endm) begin
            case (o)
                2'd0: return 4'b1111;
                2'd1: return 4'b0111;
                2'd2: return 4'b0011;
                default: return 4'b0001;
            endcase
        end else begin
            case (o)
                2'd0: return 4'b0000;
                2'd1: return 4'b1000;
                2'd2: return 4'b1100;
                default: return 4'b1110;
            endcase
        end
    endfunction

    function automatic logic [31:0] exp_data(input logic [3:0] b, input logic [31:0] d);
        return d & {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare the visible beat with one computed from a request
    task automatic check_beat(input logic [31:0] a, input logic [31:0] d, input logic e);
        logic [3:0] b;
        b = exp_be(e, a[1:0]);
        check("R7 beat valid", 64'(mem_valid), 64'd1);
        check(e ? "R2 enables" : "R1 enables", 64'(mem_be), 64'(b));
        check("R3 lane data", 64'(mem_wdata), 64'(exp_data(b, d)));
        check("R5 word address", 64'(mem_addr), 64'(a[31:2]));
        check("R4 probe flag", 64'(mem_probe), 64'(e && a[1:0] == 2'd0));
    endtask

    task automatic drive_req(input logic [31:0] a, input logic [31:0] d, input logic e);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        req_end   = e;
    endtask

    task automatic t_reset();
        check("R10 valid after reset", 64'(mem_valid), 64'd0);
        check("R10 ready after reset", 64'(req_ready), 64'd1);
    endtask

    // One isolated request: one beat, then empty
    task automatic single(input logic [31:0] a, input logic [31:0] d, input logic e);
        mem_ready = 1'b1;
        drive_req(a, d, e);
        @(negedge clk);
        req_valid = 1'b0;
        check_beat(a, d, e);
        @(negedge clk);
        check("R6 single beat", 64'(mem_valid), 64'd0);
    endtask

    task automatic t_begin_all();
        for (int o = 0; o < 4; o++)
            single(32'h0000_1230 | 32'(o), 32'hA1B2_C3D4, 1'b0);
    endtask

    task automatic t_end_all();
        for (int o = 0; o < 4; o++)
            single(32'h8000_0040 | 32'(o), 32'h5E6F_7081, 1'b1);
    endtask

    // Stall with a waiting second request, then release
    task automatic t_stall();
        mem_ready = 1'b0;
        drive_req(32'h0000_0101, 32'h1122_3344, 1'b0);
        @(negedge clk);
        check_beat(32'h0000_0101, 32'h1122_3344, 1'b0);
        drive_req(32'h0000_0207, 32'h99AA_BBCC, 1'b1);
        #1 check("R8 ready low in stall", 64'(req_ready), 64'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_beat(32'h0000_0101, 32'h1122_3344, 1'b0);
            check("R8 ready held low", 64'(req_ready), 64'd0);
        end
        mem_ready = 1'b1;
        #1 check("R9 ready on retire", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check_beat(32'h0000_0207, 32'h99AA_BBCC, 1'b1);
        @(negedge clk);
        check("R6 no repeat after stall", 64'(mem_valid), 64'd0);
    endtask

    // Back-to-back requests with continuous acceptance
    task automatic t_back2back();
        logic [31:0] aa [3];
        logic [31:0] dd [3];
        logic        ee [3];
        aa = '{32'h0000_0F03, 32'h0000_0F13, 32'h0000_0F20};
        dd = '{32'hCAFE_F00D, 32'h0BAD_BEEF, 32'h7654_3210};
        ee = '{1'b1, 1'b0, 1'b1};
        mem_ready = 1'b1;
        drive_req(aa[0], dd[0], ee[0]);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_beat(aa[k], dd[k], ee[k]);
            if (k < 2) begin
                drive_req(aa[k+1], dd[k+1], ee[k+1]);
                #1 check("R9 ready back-to-back", 64'(req_ready), 64'd1);
            end else begin
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R6 stream ends", 64'(mem_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_begin_all();
        t_end_all();
        t_stall();
        t_back2back();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule